// File: doc/BRIEF.md
# Floating-Point Operate Instruction Decoder

This block takes one 32-bit floating-point operate instruction word and reports what it asks for. It names the operation class. It gives the operand format of each of the two sources and of the destination: none, single, double, quad or 32-bit integer. It also gives the three register indices taken from the word. The block performs no arithmetic and never touches a register file. Its job is to tell the execution stage, before any operand is read, whether the instruction can be carried out.

Two conditions make an instruction unusable. First, the word may fall outside the supported opcode set, which is reported as unimplemented. Second, the word may be a supported operation whose register numbers break the alignment rule for their formats, or a compare whose destination field is not zero. That case is reported with trap type 6, meaning invalid register. The decode is combinational. The parameter `REG_OUT` places a register on every output, which adds one cycle of latency.

Top module: `fp_op_decoder`

## Requirements
- R1: A word is decoded only when bits [31:30] are 2'b10 and bits [24:19] are 6'h34 (arithmetic group) or 6'h35 (compare group). Any other word gives unimpl=1, decValid=0 and trapType=0.
- R2: The register indices are always taken from the same bits: rs1Idx=instr[18:14], rs2Idx=instr[4:0] and rdIdx=instr[29:25]. The opcode is instr[13:5].
- R3: In the arithmetic group, opcodes 0x041/042/043 (add), 0x045/046/047 (subtract), 0x049/04A/04B (multiply) and 0x04D/04E/04F (divide) use the single, double and quad format respectively for rs1, rs2 and rd. The class codes are add=1, subtract=2, multiply=3 and divide=4. The format codes are none=0, single=1, double=2, quad=3 and integer=4.
- R4: Square root uses 0x029/02A/02B for single, double and quad, with class code 5. rs1 is marked unused (format 0), and its register number is never checked for alignment.
- R5: Move 0x001 (class 6), negate 0x005 (class 7) and absolute 0x009 (class 8) use a single-format rs2 and rd, and no rs1.
- R6: Widening multiply (class 9) comes in two forms. Opcode 0x069 takes single sources and gives a double result. Opcode 0x06E takes double sources and gives a quad result.
- R7: Conversions (class 10) use rs2 and rd only. Integer to single, double and quad is 0x0C4, 0x0C8 and 0x0CC. Single, double and quad to integer is 0x0D1, 0x0D2 and 0x0D3. The format changes are 0x0C9 (single to double), 0x0CD (single to quad), 0x0C6 (double to single), 0x0CE (double to quad), 0x0C7 (quad to single) and 0x0CB (quad to double).
- R8: In the compare group, opcodes 0x051/052/053 are quiet compares (class 11) and 0x055/056/057 are signalling compares (class 12). Both use single, double and quad sources respectively, and rd format 0.
- R9: A double-format operand whose register index has bit 0 set gives trapType=6 and decValid=0.
- R10: A quad-format operand whose register index has bit 1 or bit 0 set gives trapType=6 and decValid=0.
- R11: A compare whose rd field is nonzero gives trapType=6 and decValid=0.
- R12: An opcode outside the R3-R8 set for its group gives unimpl=1, opClass=0 and all three formats 0. This includes a compare opcode placed in the arithmetic group. Exactly one of decValid, unimpl and a nonzero trapType is set at any time, or none of them.
- R13: With REG_OUT=1, every output shows the decode of the word that was present at the previous rising clock edge. While rstN is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Active-low reset |
| instr | input | 32 | Instruction word to decode |
| opClass | output | 4 | Operation class code |
| rs1Fmt | output | 3 | Format of source 1 |
| rs2Fmt | output | 3 | Format of source 2 |
| rdFmt | output | 3 | Format of the destination |
| rs1Idx | output | 5 | Register index of source 1 |
| rs2Idx | output | 5 | Register index of source 2 |
| rdIdx | output | 5 | Register index of the destination |
| decValid | output | 1 | Supported instruction with legal registers |
| unimpl | output | 1 | Word is not a supported operation |
| trapType | output | 3 | 6 on a register violation, otherwise 0 |

## Verification
The bench builds two copies of the decoder and drives both with the same words. One copy has REG_OUT=1 and the other REG_OUT=0. This exposes both the one-cycle registered timing, with its cleared reset state, and the same-cycle combinational decode. Comparing them word by word shows that the register changes only the timing and never the decoded result. Misaligned indices are placed in each operand slot in turn, including the unused rs1 of single-source operations, so that every alignment path is driven separately.

// File: rtl/fpdec_pkg.sv
package fpdec_pkg;

  typedef enum logic [2:0] {
    FMT_NONE = 3'd0,
    FMT_SGL  = 3'd1,
    FMT_DBL  = 3'd2,
    FMT_QUAD = 3'd3,
    FMT_INT  = 3'd4
  } opFmt_e;

  typedef enum logic [3:0] {
    CLS_NONE  = 4'd0,
    CLS_ADD   = 4'd1,
    CLS_SUB   = 4'd2,
    CLS_MUL   = 4'd3,
    CLS_DIV   = 4'd4,
    CLS_SQRT  = 4'd5,
    CLS_MOV   = 4'd6,
    CLS_NEG   = 4'd7,
    CLS_ABS   = 4'd8,
    CLS_WMUL  = 4'd9,
    CLS_CVT   = 4'd10,
    CLS_CMP   = 4'd11,
    CLS_CMPE  = 4'd12
  } opClass_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     known;
    logic     rdMustBeZero;
    opClass_e cls;
    opFmt_e   fmtA;
    opFmt_e   fmtB;
    opFmt_e   fmtD;
  } decStrobe_t;

  localparam logic [2:0] TRAP_BAD_REG = 3'd6;
  localparam logic [7:0] GRP_ARITH    = {2'b10, 6'h34};
  localparam logic [7:0] GRP_CMP      = {2'b10, 6'h35};

endpackage

// File: rtl/fpdec_align.sv
module fpdec_align
  import fpdec_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  opFmt_e             fmt,
  input  logic [IDX_W-1:0]   idx,
  output logic               bad
);
  always_comb begin
    unique case (fmt)
      FMT_DBL:  bad = idx[0];
      FMT_QUAD: bad = |idx[1:0];
      default:  bad = 1'b0;
    endcase
  end
endmodule

// File: rtl/fpdec_ctrl.sv
module fpdec_ctrl
  import fpdec_pkg::*;
#(
  parameter int OPC_W = 9,
  parameter int GRP_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [GRP_W-1:0] grpField,
  input  logic [OPC_W-1:0] opField,
  output decStrobe_t       strobe
);

  logic inArith;
  logic inCmp;

  assign inArith = (grpField == GRP_ARITH);
  assign inCmp   = (grpField == GRP_CMP);

  function automatic opFmt_e sizeOf(input logic [1:0] low);
    case (low)
      2'd1:    return FMT_SGL;
      2'd2:    return FMT_DBL;
      2'd3:    return FMT_QUAD;
      default: return FMT_NONE;
    endcase
  endfunction

  opFmt_e sz;
  assign sz = sizeOf(opField[1:0]);

  always_comb begin
    strobe = '{known: 1'b0, rdMustBeZero: 1'b0, cls: CLS_NONE,
               fmtA: FMT_NONE, fmtB: FMT_NONE, fmtD: FMT_NONE};
    if (inArith) begin
      strobe.known = 1'b1;
      case (opField)
        9'h041, 9'h042, 9'h043: begin
          strobe.cls = CLS_ADD; strobe.fmtA = sz; strobe.fmtB = sz; strobe.fmtD = sz;
        end
        9'h045, 9'h046, 9'h047: begin
          strobe.cls = CLS_SUB; strobe.fmtA = sz; strobe.fmtB = sz; strobe.fmtD = sz;
        end
        9'h049, 9'h04A, 9'h04B: begin
          strobe.cls = CLS_MUL; strobe.fmtA = sz; strobe.fmtB = sz; strobe.fmtD = sz;
        end
        9'h04D, 9'h04E, 9'h04F: begin
          strobe.cls = CLS_DIV; strobe.fmtA = sz; strobe.fmtB = sz; strobe.fmtD = sz;
        end
        9'h029, 9'h02A, 9'h02B: begin
          strobe.cls = CLS_SQRT; strobe.fmtB = sz; strobe.fmtD = sz;
        end
        9'h001: begin strobe.cls = CLS_MOV; strobe.fmtB = FMT_SGL; strobe.fmtD = FMT_SGL; end
        9'h005: begin strobe.cls = CLS_NEG; strobe.fmtB = FMT_SGL; strobe.fmtD = FMT_SGL; end
        9'h009: begin strobe.cls = CLS_ABS; strobe.fmtB = FMT_SGL; strobe.fmtD = FMT_SGL; end
        9'h069: begin
          strobe.cls = CLS_WMUL; strobe.fmtA = FMT_SGL; strobe.fmtB = FMT_SGL; strobe.fmtD = FMT_DBL;
        end
        9'h06E: begin
          strobe.cls = CLS_WMUL; strobe.fmtA = FMT_DBL; strobe.fmtB = FMT_DBL; strobe.fmtD = FMT_QUAD;
        end
        9'h0C4: begin strobe.cls = CLS_CVT; strobe.fmtB = FMT_INT;  strobe.fmtD = FMT_SGL;  end
        9'h0C8: begin strobe.cls = CLS_CVT; strobe.fmtB = FMT_INT;  strobe.fmtD = FMT_DBL;  end
        9'h0CC: begin strobe.cls = CLS_CVT; strobe.fmtB = FMT_INT;  strobe.fmtD = FMT_QUAD; end
        9'h0D1: begin strobe.cls = CLS_CVT; strobe.fmtB = FMT_SGL;  strobe.fmtD = FMT_INT;  end
        9'h0D2: begin strobe.cls = CLS_CVT; strobe.fmtB = FMT_DBL;  strobe.fmtD = FMT_INT;  end
        9'h0D3: begin strobe.cls = CLS_CVT; strobe.fmtB = FMT_QUAD; strobe.fmtD = FMT_INT;  end
        9'h0C9: begin strobe.cls = CLS_CVT; strobe.fmtB = FMT_SGL;  strobe.fmtD = FMT_DBL;  end
        9'h0CD: begin strobe.cls = CLS_CVT; strobe.fmtB = FMT_SGL;  strobe.fmtD = FMT_QUAD; end
        9'h0C6: begin strobe.cls = CLS_CVT; strobe.fmtB = FMT_DBL;  strobe.fmtD = FMT_SGL;  end
        9'h0CE: begin strobe.cls = CLS_CVT; strobe.fmtB = FMT_DBL;  strobe.fmtD = FMT_QUAD; end
        9'h0C7: begin strobe.cls = CLS_CVT; strobe.fmtB = FMT_QUAD; strobe.fmtD = FMT_SGL;  end
        9'h0CB: begin strobe.cls = CLS_CVT; strobe.fmtB = FMT_QUAD; strobe.fmtD = FMT_DBL;  end
        default: strobe.known = 1'b0;
      endcase
    end else if (inCmp) begin
      strobe.known = 1'b1;
      strobe.rdMustBeZero = 1'b1;
      case (opField)
        9'h051, 9'h052, 9'h053: begin strobe.cls = CLS_CMP;  strobe.fmtA = sz; strobe.fmtB = sz; end
        9'h055, 9'h056, 9'h057: begin strobe.cls = CLS_CMPE; strobe.fmtA = sz; strobe.fmtB = sz; end
        default: begin strobe.known = 1'b0; strobe.rdMustBeZero = 1'b0; end
      endcase
    end
  end

  // R3
  known_has_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.known |-> (strobe.fmtB != FMT_NONE && strobe.cls != CLS_NONE));

  // R4
  sqrt_no_rs1_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cls == CLS_SQRT) |-> (strobe.fmtA == FMT_NONE));

  // R8
  cmp_group_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdMustBeZero |-> (inCmp && strobe.fmtD == FMT_NONE));

endmodule

// File: rtl/fpdec_dp.sv
module fpdec_dp
  import fpdec_pkg::*;
#(
  parameter int IDX_W   = 5,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] rs1Field,
  input  logic [IDX_W-1:0] rs2Field,
  input  logic [IDX_W-1:0] rdField,
  input  decStrobe_t       strobe,
  output opClass_e         opClass,
  output opFmt_e           rs1Fmt,
  output opFmt_e           rs2Fmt,
  output opFmt_e           rdFmt,
  output logic [IDX_W-1:0] rs1Idx,
  output logic [IDX_W-1:0] rs2Idx,
  output logic [IDX_W-1:0] rdIdx,
  output logic             decValid,
  output logic             unimpl,
  output logic [2:0]       trapType
);

  localparam int N_OPND = 3;

  typedef struct packed {
    opClass_e         cls;
    opFmt_e           fA;
    opFmt_e           fB;
    opFmt_e           fD;
    logic [IDX_W-1:0] iA;
    logic [IDX_W-1:0] iB;
    logic [IDX_W-1:0] iD;
    logic             ok;
    logic             noImp;
    logic [2:0]       trap;
  } decOut_t;

  opFmt_e           fmtArr [N_OPND];
  logic [IDX_W-1:0] idxArr [N_OPND];
  logic [N_OPND-1:0] badArr;

  assign fmtArr[0] = strobe.fmtA;
  assign fmtArr[1] = strobe.fmtB;
  assign fmtArr[2] = strobe.fmtD;
  assign idxArr[0] = rs1Field;
  assign idxArr[1] = rs2Field;
  assign idxArr[2] = rdField;

  for (genvar g = 0; g < N_OPND; g++) begin : g_align
    fpdec_align #(.IDX_W(IDX_W)) u_align (
      .fmt (fmtArr[g]),
      .idx (idxArr[g]),
      .bad (badArr[g])
    );
  end

  logic    rdNonZero;
  logic    anyBad;
  decOut_t nxt;
  decOut_t cur;

  assign rdNonZero = strobe.rdMustBeZero && (rdField != '0);
  assign anyBad    = (|badArr) || rdNonZero;

  always_comb begin
    nxt.cls   = strobe.cls;
    nxt.fA    = strobe.fmtA;
    nxt.fB    = strobe.fmtB;
    nxt.fD    = strobe.fmtD;
    nxt.iA    = rs1Field;
    nxt.iB    = rs2Field;
    nxt.iD    = rdField;
    nxt.ok    = strobe.known && !anyBad;
    nxt.noImp = !strobe.known;
    nxt.trap  = (strobe.known && anyBad) ? TRAP_BAD_REG : 3'd0;
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cur <= '0;
      else       cur <= nxt;
    end
  end else begin : g_comb
    assign cur = nxt;
  end

  assign opClass  = cur.cls;
  assign rs1Fmt   = cur.fA;
  assign rs2Fmt   = cur.fB;
  assign rdFmt    = cur.fD;
  assign rs1Idx   = cur.iA;
  assign rs2Idx   = cur.iB;
  assign rdIdx    = cur.iD;
  assign decValid = cur.ok;
  assign unimpl   = cur.noImp;
  assign trapType = cur.trap;

  // R9
  dbl_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && rdFmt == FMT_DBL) |-> !rdIdx[0]);

  // R10
  quad_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && rs2Fmt == FMT_QUAD) |-> (rs2Idx[1:0] == 2'b00));

  // R11
  cmp_rd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && (opClass == CLS_CMP || opClass == CLS_CMPE)) |-> (rdIdx == '0));

  // R12
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({decValid, unimpl, trapType != 3'd0}));

  // R12
  unimpl_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    unimpl |-> (opClass == CLS_NONE && rs2Fmt == FMT_NONE && trapType == 3'd0));

endmodule

// File: rtl/fp_op_decoder.sv
module fp_op_decoder
  import fpdec_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] instr,
  output logic [3:0]  opClass,
  output logic [2:0]  rs1Fmt,
  output logic [2:0]  rs2Fmt,
  output logic [2:0]  rdFmt,
  output logic [4:0]  rs1Idx,
  output logic [4:0]  rs2Idx,
  output logic [4:0]  rdIdx,
  output logic        decValid,
  output logic        unimpl,
  output logic [2:0]  trapType
);

  localparam int IDX_W   = 5;
  localparam int OPC_W   = 9;
  localparam int OPC_LSB = 5;
  localparam int RS1_LSB = 14;
  localparam int RS2_LSB = 0;
  localparam int RD_LSB  = 25;
  localparam int GRP_W   = 8;

  decStrobe_t strobe;
  opClass_e   clsW;
  opFmt_e     f1W, f2W, fdW;

  fpdec_ctrl #(.OPC_W(OPC_W), .GRP_W(GRP_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .grpField ({instr[31:30], instr[24:19]}),
    .opField  (instr[OPC_LSB +: OPC_W]),
    .strobe   (strobe)
  );

  fpdec_dp #(.IDX_W(IDX_W), .REG_OUT(REG_OUT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .rs1Field (instr[RS1_LSB +: IDX_W]),
    .rs2Field (instr[RS2_LSB +: IDX_W]),
    .rdField  (instr[RD_LSB +: IDX_W]),
    .strobe   (strobe),
    .opClass  (clsW),
    .rs1Fmt   (f1W),
    .rs2Fmt   (f2W),
    .rdFmt    (fdW),
    .rs1Idx   (rs1Idx),
    .rs2Idx   (rs2Idx),
    .rdIdx    (rdIdx),
    .decValid (decValid),
    .unimpl   (unimpl),
    .trapType (trapType)
  );

  assign opClass = clsW;
  assign rs1Fmt  = f1W;
  assign rs2Fmt  = f2W;
  assign rdFmt   = fdW;

endmodule

// File: tb/fp_op_decoder_tb.sv
module fp_op_decoder_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] instr = '0;
  int          nChecks = 0;
  int          nFails = 0;

  always #5 clk = ~clk;

  logic [3:0] rCls, cCls;
  logic [2:0] rF1, rF2, rFd, cF1, cF2, cFd, rTr, cTr;
  logic [4:0] rI1, rI2, rId, cI1, cI2, cId;
  logic       rV, rU, cV, cU;

  fp_op_decoder #(.REG_OUT(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .instr(instr),
    .opClass(rCls), .rs1Fmt(rF1), .rs2Fmt(rF2), .rdFmt(rFd),
    .rs1Idx(rI1), .rs2Idx(rI2), .rdIdx(rId),
    .decValid(rV), .unimpl(rU), .trapType(rTr));

  fp_op_decoder #(.REG_OUT(1'b0)) u_comb (
    .clk(clk), .rstN(rstN), .instr(instr),
    .opClass(cCls), .rs1Fmt(cF1), .rs2Fmt(cF2), .rdFmt(cFd),
    .rs1Idx(cI1), .rs2Idx(cI2), .rdIdx(cId),
    .decValid(cV), .unimpl(cU), .trapType(cTr));

  function automatic logic [31:0] mk(bit cmp, int op, int rd, int rs1, int rs2);
    logic [5:0] grp = cmp ? 6'h35 : 6'h34;
    return {2'b10, rd[4:0], grp, rs1[4:0], op[8:0], rs2[4:0]};
  endfunction

  function automatic logic [35:0] regVec();
    return {rCls, rF1, rF2, rFd, rV, rU, rTr, rI1, rI2, rId};
  endfunction

  function automatic logic [35:0] combVec();
    return {cCls, cF1, cF2, cFd, cV, cU, cTr, cI1, cI2, cId};
  endfunction

  task automatic chk(string tag, logic [35:0] act, logic [35:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drives a word and checks both instances; indices per R2 field positions
  task automatic expectDec(string tag, logic [31:0] w, int cls, int f1, int f2, int fd,
                           bit v, bit u, int tr);
    logic [35:0] e;
    e = {cls[3:0], f1[2:0], f2[2:0], fd[2:0], v, u, tr[2:0], w[18:14], w[4:0], w[29:25]};
    @(negedge clk);
    instr = w;
    #1;
    chk({tag, " comb"}, combVec(), e);
    @(posedge clk);
    #1;
    chk({tag, " reg"}, regVec(), e);
  endtask

  task automatic testReset();
    instr = mk(0, 'h041, 2, 4, 6);
    repeat (2) @(posedge clk);
    #1;
    // R13 reset state zero on the registered copy
    chk("R13 reset", regVec(), '0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testGroupSelect();
    // R1: wrong top bits, wrong group value
    expectDec("R1 top bits", {2'b11, mk(0, 'h041, 1, 2, 3)[29:0]}, 0, 0, 0, 0, 0, 1, 0);
    expectDec("R1 group 0x36", {mk(0, 'h041, 1, 2, 3)[31:25], 6'h36, mk(0, 'h041, 1, 2, 3)[18:0]},
              0, 0, 0, 0, 0, 1, 0);
  endtask

  task automatic testFields();
    // R2 field positions with distinct indices
    expectDec("R2 fields", mk(0, 'h041, 5'h1B, 5'h0E, 5'h15), 1, 1, 1, 1, 1, 0, 0);
  endtask

  task automatic testArith();
    // R3
    expectDec("R3 add d", mk(0, 'h042, 2, 4, 6), 1, 2, 2, 2, 1, 0, 0);
    expectDec("R3 sub q", mk(0, 'h047, 4, 8, 12), 2, 3, 3, 3, 1, 0, 0);
    expectDec("R3 mul s", mk(0, 'h049, 3, 5, 7), 3, 1, 1, 1, 1, 0, 0);
    expectDec("R3 div d", mk(0, 'h04E, 30, 0, 16), 4, 2, 2, 2, 1, 0, 0);
  endtask

  task automatic testSqrt();
    // R4: odd rs1 on a quad sqrt must be ignored
    expectDec("R4 sqrt q", mk(0, 'h02B, 8, 7, 4), 5, 0, 3, 3, 1, 0, 0);
    expectDec("R4 sqrt s", mk(0, 'h029, 1, 3, 9), 5, 0, 1, 1, 1, 0, 0);
  endtask

  task automatic testMoves();
    // R5
    expectDec("R5 mov", mk(0, 'h001, 3, 1, 5), 6, 0, 1, 1, 1, 0, 0);
    expectDec("R5 neg", mk(0, 'h005, 7, 0, 9), 7, 0, 1, 1, 1, 0, 0);
    expectDec("R5 abs", mk(0, 'h009, 11, 0, 13), 8, 0, 1, 1, 1, 0, 0);
  endtask

  task automatic testWideMul();
    // R6
    expectDec("R6 s to d", mk(0, 'h069, 2, 3, 5), 9, 1, 1, 2, 1, 0, 0);
    expectDec("R6 d to q", mk(0, 'h06E, 4, 2, 6), 9, 2, 2, 3, 1, 0, 0);
    expectDec("R6 q dest misaligned", mk(0, 'h06E, 6, 2, 6), 9, 2, 2, 3, 0, 0, 6);
  endtask

  task automatic testConvert();
    // R7
    expectDec("R7 i to s", mk(0, 'h0C4, 1, 0, 3), 10, 0, 4, 1, 1, 0, 0);
    expectDec("R7 i to q", mk(0, 'h0CC, 8, 0, 3), 10, 0, 4, 3, 1, 0, 0);
    expectDec("R7 q to i", mk(0, 'h0D3, 5, 0, 12), 10, 0, 3, 4, 1, 0, 0);
    expectDec("R7 d to s", mk(0, 'h0C6, 5, 0, 2), 10, 0, 2, 1, 1, 0, 0);
    expectDec("R7 s to q", mk(0, 'h0CD, 4, 0, 7), 10, 0, 1, 3, 1, 0, 0);
    expectDec("R7 q to d", mk(0, 'h0CB, 2, 0, 4), 10, 0, 3, 2, 1, 0, 0);
  endtask

  task automatic testCompare();
    // R8
    expectDec("R8 cmp s", mk(1, 'h051, 0, 3, 5), 11, 1, 1, 0, 1, 0, 0);
    expectDec("R8 cmpe d", mk(1, 'h056, 0, 2, 4), 12, 2, 2, 0, 1, 0, 0);
    expectDec("R8 cmp q", mk(1, 'h053, 0, 4, 8), 11, 3, 3, 0, 1, 0, 0);
  endtask

  task automatic testDblAlign();
    // R9: each operand slot odd in turn
    expectDec("R9 rs1 odd", mk(0, 'h042, 2, 5, 6), 1, 2, 2, 2, 0, 0, 6);
    expectDec("R9 rs2 odd", mk(0, 'h042, 2, 4, 7), 1, 2, 2, 2, 0, 0, 6);
    expectDec("R9 rd odd", mk(0, 'h042, 3, 4, 6), 1, 2, 2, 2, 0, 0, 6);
  endtask

  task automatic testQuadAlign();
    // R10
    expectDec("R10 rs1 bit1", mk(0, 'h043, 4, 2, 8), 1, 3, 3, 3, 0, 0, 6);
    expectDec("R10 rs2 bit0", mk(0, 'h043, 4, 8, 9), 1, 3, 3, 3, 0, 0, 6);
    expectDec("R10 rd bit1", mk(0, 'h043, 6, 8, 12), 1, 3, 3, 3, 0, 0, 6);
  endtask

  task automatic testCmpRd();
    // R11
    expectDec("R11 rd nonzero", mk(1, 'h051, 1, 3, 5), 11, 1, 1, 0, 0, 0, 6);
    expectDec("R11 rd nonzero e", mk(1, 'h057, 16, 4, 8), 12, 3, 3, 0, 0, 0, 6);
  endtask

  task automatic testUnknown();
    // R12
    expectDec("R12 unknown arith", mk(0, 'h044, 2, 4, 6), 0, 0, 0, 0, 0, 1, 0);
    expectDec("R12 cmp in arith", mk(0, 'h051, 0, 4, 6), 0, 0, 0, 0, 0, 1, 0);
    expectDec("R12 arith in cmp", mk(1, 'h041, 0, 4, 6), 0, 0, 0, 0, 0, 1, 0);
    expectDec("R12 misaligned unknown", mk(1, 'h054, 3, 1, 1), 0, 0, 0, 0, 0, 1, 0);
  endtask

  task automatic testLatency();
    logic [35:0] eA;
    logic [31:0] wA;
    wA = mk(0, 'h04A, 6, 10, 14);
    eA = {4'd3, 3'd2, 3'd2, 3'd2, 1'b1, 1'b0, 3'd0, 5'd10, 5'd14, 5'd6};
    @(negedge clk);
    instr = wA;
    @(posedge clk);
    @(negedge clk);
    instr = mk(0, 'h1FF, 6, 10, 14);
    #1;
    // R13 registered copy still holds the previous decode
    chk("R13 hold", regVec(), eA);
    @(posedge clk);
    #1;
    chk("R13 update", regVec(), {4'd0, 9'd0, 1'b0, 1'b1, 3'd0, 5'd10, 5'd14, 5'd6});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    testReset();
    testGroupSelect();
    testFields();
    testArith();
    testSqrt();
    testMoves();
    testWideMul();
    testConvert();
    testCompare();
    testDblAlign();
    testQuadAlign();
    testCmpRd();
    testUnknown();
    testLatency();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule